// File: doc/BRIEF.md
# Bus Hold and Interrupt Arbiter

This block sits beside a bus master's bus sequencer. It decides, at each bus-cycle boundary, whether the master should accept an interrupt or hand the bus to an outside requester. Two interrupt sources are handled. The maskable request is a level and is gated by an enable flag. The non-maskable request is edge-detected through a synchroniser and cannot be masked. An active-low lock input holds off both bus grants and interrupt acceptance for as long as it is low.

The bus can be handed over in one of two ways, chosen by a parameter. In hold mode, a HOLD level request is answered with an HLDA level. In request/grant mode, each of several prioritised channels shares one open-drain line. On that line a one-clock low pulse carries the request, then the grant, then the release. The block raises a release-bus signal toward the sequencer for as long as an outside requester owns the bus. For every accepted interrupt it reports a one-cycle taken pulse together with the interrupt's type.

Top module: `bus_hold_intr_arb`

## Requirements
- R1: With `int_en` high, a high `intr_req` sampled on a clock edge where `cyc_end` is high is accepted. In the next cycle `irq_take` is 1 for one cycle, `irq_is_nmi` is 0, and `inta_n` is 0 for that cycle. The request is a level, so it is accepted again at each later boundary while it stays high.
- R2: With `int_en` low, `intr_req` is never accepted, and `inta_n` stays 1.
- R3: A rising edge on `nmi_in` is passed through a two-flop synchroniser and sets a pending flag. The flag is accepted at the next permitted boundary even with `int_en` low. Acceptance gives `irq_take`=1 and `irq_is_nmi`=1, and `inta_n` stays 1. An input held high is accepted only once.
- R4: When a pending non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is accepted first. The maskable one is accepted at the next boundary.
- R5: Interrupts are accepted only on edges where `cyc_end` is 1. Bus grants in either mode are given only on such edges.
- R6: While `lock_n` is 0, no interrupt is accepted and no grant is given. A pending non-maskable request is kept and is accepted once `lock_n` returns to 1.
- R7: In hold mode, a high `hold_req` at a permitted boundary sets `hlda` to 1 from the next cycle. `bus_release` follows `hlda`.
- R8: In hold mode, `hlda` falls one clock after `hold_req` is seen low. No interrupt is accepted while the bus is released. If a grant and an interrupt fall on the same boundary, the grant wins and the interrupt stays pending.
- R9: In request/grant mode, a channel requests by pulling its line low (`rq_line_n[i]`=0) for one clock. The block grants by setting `rq_pull[i]`=1 for exactly one cycle; an asserted `rq_pull[i]` drives line i low. A later one-clock low pulse from the owner releases the bus, and `bus_release` is 1 from the grant cycle until that release has been sampled.
- R10: When channels request together, the lowest index is granted first. The other channel's request is kept and is granted after the release. At most one `rq_pull` bit is set at a time.
- R11: The block ignores the low level that its own grant pulse puts on a line. After a release with no new request, no further grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intr_req | input | 1 | Maskable interrupt request, level, active high |
| nmi_in | input | 1 | Non-maskable interrupt, asynchronous, rising edge |
| int_en | input | 1 | Enable flag for the maskable request |
| hold_req | input | 1 | Bus hold request (hold mode) |
| lock_n | input | 1 | Active-low bus lock; low blocks grants and interrupts |
| cyc_end | input | 1 | Bus-cycle-boundary strobe |
| rq_line_n | input | NUM_CH | Sensed level of each request/grant line |
| inta_n | output | 1 | Active-low acknowledge for the maskable request |
| hlda | output | 1 | Hold acknowledge (hold mode) |
| bus_release | output | 1 | Bus currently handed to an outside requester |
| irq_take | output | 1 | One-cycle pulse: interrupt accepted |
| irq_is_nmi | output | 1 | Type of the accepted interrupt, 1 = non-maskable |
| rq_pull | output | NUM_CH | Open-drain enable; 1 drives that line low |

## Verification
A bus grant and an interrupt acceptance can both become due on the same boundary strobe. The bench provokes this in hold mode in two ways. First, it raises HOLD together with an enabled maskable request. Second, it raises HOLD while a non-maskable edge is already pending. Each case is judged by HLDA rising with no taken pulse in that cycle, and by the waiting interrupt being taken exactly once, one boundary after HLDA has fallen. In request/grant mode, two channels requesting in the same clock are judged by the order and spacing of the grant pulses.

// File: rtl/arb_pkg.sv
// Shared types for the bus hold / interrupt arbiter.
// Assumes nothing beyond a synthesizable enum encoding.
package arb_pkg;
    // Ownership of the external bus as seen by the arbiter.
    typedef enum logic {
        OWN_LOCAL = 1'b0,
        OWN_EXT   = 1'b1
    } bus_own_e;
endpackage

// File: rtl/nmi_edge_catch.sv
// Synchronises the asynchronous non-maskable input, detects its rising
// edge and holds a pending flag until the service logic clears it.
// Assumes SYNC_STAGES >= 2; a new edge in the clearing cycle wins.
module nmi_edge_catch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_async,
    input  logic clear,
    output logic pend
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               rise;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], nmi_async};
    end

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    // Latch a detected edge until it is serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= rise | (pend & ~clear);
    end
endmodule

// File: rtl/irq_select.sv
// Chooses which interrupt, if any, is accepted at a bus-cycle boundary
// and registers the taken pulse, its type and the active-low acknowledge.
// Assumes bus_busy is high whenever the bus is released or being granted.
module irq_select (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_end,
    input  logic lock_n,
    input  logic bus_busy,
    input  logic nmi_pend,
    input  logic intr_req,
    input  logic int_en,
    output logic nmi_clear,
    output logic irq_take,
    output logic irq_is_nmi,
    output logic inta_n
);
    logic take_ok;
    logic take_nmi;
    logic take_int;

    // Acceptance window and priority: non-maskable before maskable.
    always_comb begin
        take_ok  = cyc_end & lock_n & ~bus_busy;
        take_nmi = take_ok & nmi_pend;
        take_int = take_ok & ~nmi_pend & intr_req & int_en;
    end

    assign nmi_clear = take_nmi;

    // Register the one-cycle outcome toward the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take   <= 1'b0;
            irq_is_nmi <= 1'b0;
            inta_n     <= 1'b1;
        end else begin
            irq_take   <= take_nmi | take_int;
            irq_is_nmi <= take_nmi;
            inta_n     <= ~take_int;
        end
    end
endmodule

// File: rtl/hold_grant_fsm.sv
// Level HOLD / HLDA handshake: grants at a permitted boundary and gives
// the bus back one clock after the request is seen low.
// Assumes hold_req is synchronous to clk.
module hold_grant_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cyc_end,
    input  logic lock_n,
    output logic grant_now,
    output logic hlda
);
    bus_own_e state;

    assign grant_now = (state == OWN_LOCAL) & hold_req & cyc_end & lock_n;

    // Track ownership; HLDA is the registered ownership state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OWN_LOCAL;
        end else if (state == OWN_LOCAL) begin
            if (grant_now) state <= OWN_EXT;
        end else if (!hold_req) begin
            state <= OWN_LOCAL;
        end
    end

    assign hlda = (state == OWN_EXT);
endmodule

// File: rtl/rqgt_grant_fsm.sv
// Pulse-based request/grant over shared open-drain lines, one per channel.
// Requests are latched, the lowest index wins, a one-cycle pull is the
// grant and the owner's next low pulse releases the bus.
// Assumes NUM_CH >= 2 and one-clock request and release pulses.
module rqgt_grant_fsm
    import arb_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rq_line_n,
    input  logic              cyc_end,
    input  logic              lock_n,
    output logic              grant_now,
    output logic              owned,
    output logic [NUM_CH-1:0] rq_pull
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    bus_own_e          state;
    logic [CH_W-1:0]   owner;
    logic [CH_W-1:0]   pick;
    logic              any_pend;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] pend_nx;
    logic [NUM_CH-1:0] pull_nx;
    logic [NUM_CH-1:0] line_low;

    // Foreign low levels only; our own grant pulse is masked out.
    assign line_low = ~rq_line_n & ~rq_pull;

    // Lowest pending channel has priority.
    always_comb begin
        pick     = '0;
        any_pend = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick     = CH_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    assign grant_now = (state == OWN_LOCAL) & any_pend & cyc_end & lock_n;
    assign owned     = (state == OWN_EXT);

    // Next pending set and next grant pulse.
    always_comb begin
        pend_nx = pend;
        pull_nx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant_now && pick == CH_W'(i)) begin
                pend_nx[i] = 1'b0;
                pull_nx[i] = 1'b1;
            end else if (line_low[i] && !(owned && owner == CH_W'(i))) begin
                pend_nx[i] = 1'b1;
            end
        end
    end

    // Ownership, owner index, pending requests and the open-drain pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= OWN_LOCAL;
            owner   <= '0;
            pend    <= '0;
            rq_pull <= '0;
        end else begin
            pend    <= pend_nx;
            rq_pull <= pull_nx;
            if (grant_now) begin
                state <= OWN_EXT;
                owner <= pick;
            end else if (owned && line_low[owner]) begin
                state <= OWN_LOCAL;
            end
        end
    end
endmodule

// File: rtl/bus_hold_intr_arb.sv
// Top of the arbiter: non-maskable edge capture, interrupt selection and
// one of two bus hand-over schemes chosen by USE_RQGT.
// Assumes all inputs except nmi_in are synchronous to clk.
module bus_hold_intr_arb #(
    parameter bit USE_RQGT    = 1'b0,
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_req,
    input  logic              nmi_in,
    input  logic              int_en,
    input  logic              hold_req,
    input  logic              lock_n,
    input  logic              cyc_end,
    input  logic [NUM_CH-1:0] rq_line_n,
    output logic              inta_n,
    output logic              hlda,
    output logic              bus_release,
    output logic              irq_take,
    output logic              irq_is_nmi,
    output logic [NUM_CH-1:0] rq_pull
);
    logic nmi_pend;
    logic nmi_clear;
    logic grant_now;
    logic unused_mode_in;

    assign unused_mode_in = ^{rq_line_n, hold_req};

    nmi_edge_catch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_async(nmi_in),
        .clear    (nmi_clear),
        .pend     (nmi_pend)
    );

    generate
        if (USE_RQGT) begin : g_rqgt
            logic owned;
            rqgt_grant_fsm #(.NUM_CH(NUM_CH)) u_rqgt (
                .clk      (clk),
                .rst_n    (rst_n),
                .rq_line_n(rq_line_n),
                .cyc_end  (cyc_end),
                .lock_n   (lock_n),
                .grant_now(grant_now),
                .owned    (owned),
                .rq_pull  (rq_pull)
            );
            assign hlda        = 1'b0;
            assign bus_release = owned;
        end else begin : g_hold
            logic hlda_i;
            hold_grant_fsm u_hold (
                .clk      (clk),
                .rst_n    (rst_n),
                .hold_req (hold_req),
                .cyc_end  (cyc_end),
                .lock_n   (lock_n),
                .grant_now(grant_now),
                .hlda     (hlda_i)
            );
            assign hlda        = hlda_i;
            assign bus_release = hlda_i;
            assign rq_pull     = '0;
        end
    endgenerate

    irq_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_end   (cyc_end),
        .lock_n    (lock_n),
        .bus_busy  (bus_release | grant_now),
        .nmi_pend  (nmi_pend),
        .intr_req  (intr_req),
        .int_en    (int_en),
        .nmi_clear (nmi_clear),
        .irq_take  (irq_take),
        .irq_is_nmi(irq_is_nmi),
        .inta_n    (inta_n)
    );
endmodule

// File: rtl/arb_checker.sv
// Port-level properties of the arbiter, bound into every instance.
// Assumes the synchronous active-low reset of the top.
module arb_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_n,
    input logic              cyc_end,
    input logic              hold_req,
    input logic              inta_n,
    input logic              hlda,
    input logic              bus_release,
    input logic              irq_take,
    input logic              irq_is_nmi,
    input logic [NUM_CH-1:0] rq_pull
);
    p_inta_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n |-> (irq_take && !irq_is_nmi));

    p_take_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(cyc_end));

    p_take_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(lock_n));

    p_hlda_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> ($past(lock_n) && $past(cyc_end) && $past(hold_req)));

    p_hlda_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold_req) |=> !hlda);

    p_take_not_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !bus_release);

    p_pull_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rq_pull));

    p_pull_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_pull) |=> !(|rq_pull));

    p_pull_permitted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_pull) |-> ($past(lock_n) && $past(cyc_end)));
endmodule

bind bus_hold_intr_arb arb_checker #(.NUM_CH(NUM_CH)) u_arb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_n     (lock_n),
    .cyc_end    (cyc_end),
    .hold_req   (hold_req),
    .inta_n     (inta_n),
    .hlda       (hlda),
    .bus_release(bus_release),
    .irq_take   (irq_take),
    .irq_is_nmi (irq_is_nmi),
    .rq_pull    (rq_pull)
);

// File: tb/tb_bus_hold_intr_arb.sv
module tb_bus_hold_intr_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       intr_req = 1'b0, nmi_in = 1'b0, int_en = 1'b0;
    logic       hold_req = 1'b0, lock_n = 1'b1, cyc_end = 1'b0;
    logic [1:0] ext_rq = 2'b00;
    logic [1:0] line_h, line_r;
    logic       inta_n, hlda, bus_release, irq_take, irq_is_nmi;
    logic       r_inta_n, r_hlda, r_rel, r_take, r_nmi;
    logic [1:0] pull_h, pull_r;
    int         total = 0;
    int         fails = 0;

    always #10 clk = ~clk;

    assign line_h = ~ext_rq;
    assign line_r = ~(ext_rq | pull_r);

    bus_hold_intr_arb #(.USE_RQGT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .nmi_in(nmi_in),
        .int_en(int_en), .hold_req(hold_req), .lock_n(lock_n), .cyc_end(cyc_end),
        .rq_line_n(line_h), .inta_n(inta_n), .hlda(hlda), .bus_release(bus_release),
        .irq_take(irq_take), .irq_is_nmi(irq_is_nmi), .rq_pull(pull_h));

    bus_hold_intr_arb #(.USE_RQGT(1'b1)) dut_rg (
        .clk(clk), .rst_n(rst_n), .intr_req(1'b0), .nmi_in(1'b0),
        .int_en(1'b0), .hold_req(1'b0), .lock_n(lock_n), .cyc_end(cyc_end),
        .rq_line_n(line_r), .inta_n(r_inta_n), .hlda(r_hlda), .bus_release(r_rel),
        .irq_take(r_take), .irq_is_nmi(r_nmi), .rq_pull(pull_r));

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // {take, is_nmi, inta_n, hlda} after one cycle
    function automatic int outs();
        return int'({irq_take, irq_is_nmi, inta_n, hlda});
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // Raise a clean nmi edge and wait until it is pending (cyc_end low).
    task automatic nmi_edge();
        nmi_in = 1'b0; repeat (3) step();
        nmi_in = 1'b1; repeat (3) step();
    endtask

    task automatic rg_pulse(input logic [1:0] m);
        ext_rq = m; step(); ext_rq = 2'b00;
    endtask

    // [8]intr [7]en [6]hold [5]lock_n [4]cyc_end | [3]take [2]nmi [1]inta_n [0]hlda
    localparam logic [8:0] VEC [12] = '{
        9'b0_0_0_1_1_0010,  // idle
        9'b1_0_0_1_1_0010,  // R2 masked
        9'b1_1_0_1_0_0010,  // R5 no boundary
        9'b1_1_0_1_1_1000,  // R1 taken, inta_n low
        9'b1_1_0_0_1_0010,  // R6 locked
        9'b0_0_1_0_1_0010,  // R6 hold while locked
        9'b0_0_1_1_0_0010,  // R5 hold off boundary
        9'b1_1_1_1_1_0011,  // R8 grant beats interrupt
        9'b1_1_1_1_1_0011,  // R8 released, no take
        9'b1_1_0_1_1_0010,  // R8 hlda drops, no take
        9'b1_1_0_1_1_1000,  // R1 level retaken after return
        9'b0_1_0_1_1_0010   // idle
    };

    initial begin
        #4_000_000;
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) step();
        // Reset state (R1 R7 R9)
        chk("R1", "reset take/nmi/inta_n/hlda", outs(), 4'b0010);
        chk("R9", "reset pull/release", int'({pull_r, r_rel}), 0);
        rst_n = 1'b1;
        step();

        for (int k = 0; k < 12; k++) begin
            {intr_req, int_en, hold_req, lock_n, cyc_end} = VEC[k][8:4];
            step();
            chk("R1 R2 R5 R6 R7 R8 vector", $sformatf("row %0d", k), outs(), int'(VEC[k][3:0]));
        end
        intr_req = 0; int_en = 0; hold_req = 0; lock_n = 1; cyc_end = 0;
        step();

        // R3: edge taken with int_en low, no acknowledge
        nmi_edge();
        cyc_end = 1'b1; step();
        chk("R3", "nmi taken unmasked", outs(), 4'b1110);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R3", "held level not retaken", int'(irq_take), 0);
        end
        cyc_end = 1'b0;

        // R4: nmi and intr at the same boundary
        nmi_edge();
        intr_req = 1; int_en = 1; cyc_end = 1; step();
        chk("R4", "nmi first", outs(), 4'b1110);
        step();
        chk("R4", "intr next", outs(), 4'b1000);
        intr_req = 0; int_en = 0; cyc_end = 0;

        // R6: pending nmi held through lock
        nmi_edge();
        lock_n = 0; cyc_end = 1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R6", "locked no take", int'(irq_take), 0);
        end
        lock_n = 1; step();
        chk("R6", "nmi after unlock", outs(), 4'b1110);
        cyc_end = 0;

        // R8: grant and pending nmi on the same boundary
        nmi_edge();
        hold_req = 1; cyc_end = 1; step();
        chk("R8", "grant wins over nmi", outs(), 4'b0011);
        chk("R7", "bus_release follows hlda", int'(bus_release), 1);
        step();
        chk("R8", "no take while released", outs(), 4'b0011);
        hold_req = 0; step();
        chk("R8", "hlda drops one clock after hold low", outs(), 4'b0010);
        step();
        chk("R8", "nmi after bus return", outs(), 4'b1110);
        step();

        // R9 R10 R11: request/grant mode, cyc_end high
        rg_pulse(2'b11);
        chk("R9", "no grant in request cycle", int'({pull_r, r_rel}), 3'b000);
        step();
        chk("R10", "channel 0 granted first", int'({pull_r, r_rel}), 3'b011);
        step();
        chk("R9", "grant is one cycle", int'({pull_r, r_rel}), 3'b001);
        rg_pulse(2'b01);
        chk("R9", "release returns bus", int'({pull_r, r_rel}), 3'b000);
        step();
        chk("R10", "channel 1 granted after release", int'({pull_r, r_rel}), 3'b101);
        step();
        rg_pulse(2'b10);
        chk("R9", "channel 1 release", int'({pull_r, r_rel}), 3'b000);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R11", "own pulse not seen as request", int'({pull_r, r_rel}), 3'b000);
        end

        // R6: request/grant blocked by lock
        lock_n = 0;
        rg_pulse(2'b10);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6", "rq grant held off by lock", int'(pull_r), 0);
        end
        lock_n = 1; step();
        chk("R6", "rq grant after unlock", int'({pull_r, r_rel}), 3'b101);
        step();
        rg_pulse(2'b10);
        chk("R9", "final release", int'(r_rel), 0);

        // R5: request/grant off boundary
        cyc_end = 0;
        rg_pulse(2'b01);
        step();
        chk("R5", "rq no grant off boundary", int'(pull_r), 0);
        cyc_end = 1; step();
        chk("R5", "rq grant on boundary", int'({pull_r, r_rel}), 3'b011);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule